// File: doc/BRIEF.md
# Gated Muxed Clock Divider

This block derives one peripheral clock-enable strobe from one of two source strobes. The sources are a base input strobe and a PLL-derived strobe, and both are modelled as single-cycle enables in one system clock domain. A select bit picks the source. A programmable divider counts pulses of the chosen source and emits one output pulse for every *ratio* source pulses. A gate bit can stop the output completely.

The rule that turns the divider field into a ratio is fixed when the block is built. There are four choices: no divider (the output follows the source), N+1, 2×(N+1) and 2<<N. The field width is also a build-time parameter. A status output reports the ratio the counter is using right now.

A change to the divider field or to the select bit does not cut the running period short. The block captures the new setting only at an output period boundary, or while the counter is idle.

Top module: `gated_mux_divider`

## Requirements
- R1: While reset is asserted, `div_en_o` is low and `ratio_o` reads 1.
- R2: In doubled mode (MODE=DIVM_DOUBLE), a field value N gives a ratio of 2×(N+1): N=0 gives 2, N=2 gives 6 and N=9 gives 20.
- R3: In one-based mode (MODE=DIVM_ONE), a field value N gives a ratio of N+1. A field of 0 passes every source pulse through. The largest 4-bit field (15) gives 16.
- R4: In power-of-two mode (MODE=DIVM_POW2), a field value N gives a ratio of 2<<N: N=0 gives 2, N=3 gives 16 and N=7 gives 256.
- R5: With no divider (MODE=DIVM_NONE), the ratio is 1 and the divider field has no effect.
- R6: While `cfg_gate` is 0, `div_en_o` stays low. After `cfg_gate` returns to 1, counting restarts from zero. The first output pulse follows the ratio-th selected source pulse.
- R7: When `cfg_sel` is 0, `base_en` is counted. When `cfg_sel` is 1, `pll_en` is counted. Each output pulse appears one cycle after the source pulse that completes a period. With a source pulse every P cycles, the output pulses every ratio×P cycles.
- R8: A new divider or select value takes effect only at a period boundary. A period that is already running completes with its old ratio, so no pulse comes early.
- R9: `ratio_o` equals the ratio of the period in progress. It keeps the old value after a mid-period reprogramming until that period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Divider field |
| cfg_gate | input | 1 | 1 enables the output, 0 stops it (ignored when HAS_GATE=0) |
| cfg_sel | input | 1 | Source select: 0 base, 1 PLL |
| base_en | input | 1 | Base source strobe |
| pll_en | input | 1 | PLL source strobe |
| div_en_o | output | 1 | Divided output strobe |
| ratio_o | output | RATIO_W | Ratio currently in effect |

## Verification
The bench reprograms the doubled-mode divider from 20 down to 2 five cycles into a period. It then expects one interval of 20 followed by 2. A design that loads settings at once would emit a short pulse, and one that never reloads would stay at 20. The bench re-enables the gate and expects the first pulse after exactly one full ratio. A counter that keeps stale state would fire early. It also drives the PLL strobe at one pulse in three, which catches a select bit that is ignored or inverted. Finally, it applies the end values of each encoding: a field of 0 in one-based mode, the largest field, and the widest power-of-two shift. An off-by-one decode or an overflowing counter shows up as a wrong interval or a wrong status value.

// File: rtl/gmcd_pkg.sv
package gmcd_pkg;

   typedef enum logic [1:0] {
      DIVM_NONE   = 2'd0,
      DIVM_ONE    = 2'd1,
      DIVM_DOUBLE = 2'd2,
      DIVM_POW2   = 2'd3
   } divm_e;

   // Width that holds the largest ratio an encoding can produce.
   function automatic int ratio_width(divm_e m, int w);
      case (m)
         DIVM_NONE:   return 2;
         DIVM_ONE:    return w + 1;
         DIVM_DOUBLE: return w + 2;
         default:     return (w <= 4) ? ((1 << w) + 1) : (w + 2);
      endcase
   endfunction

endpackage

// File: rtl/gmcd_ratio_dec.sv
module gmcd_ratio_dec #(
   parameter gmcd_pkg::divm_e MODE    = gmcd_pkg::DIVM_DOUBLE,
   parameter int              DIV_W   = 8,
   parameter int              RATIO_W = 10
) (
   input  logic [DIV_W-1:0]   field_i,
   output logic [RATIO_W-1:0] ratio_o
);

   generate
      if (MODE == gmcd_pkg::DIVM_NONE) begin : g_none
         // Field is masked off: ratio is always one.
         assign ratio_o = RATIO_W'(1) | RATIO_W'(field_i & {DIV_W{1'b0}});
      end else if (MODE == gmcd_pkg::DIVM_ONE) begin : g_one
         assign ratio_o = RATIO_W'(field_i) + RATIO_W'(1);
      end else if (MODE == gmcd_pkg::DIVM_DOUBLE) begin : g_double
         assign ratio_o = (RATIO_W'(field_i) + RATIO_W'(1)) << 1;
      end else begin : g_pow2
         assign ratio_o = RATIO_W'(2) << field_i;
      end
   endgenerate

endmodule

// File: rtl/gmcd_src_pick.sv
module gmcd_src_pick #(
   parameter bit HAS_GATE = 1'b1
) (
   input  logic cfg_gate_i,
   input  logic sel_q_i,
   input  logic base_en_i,
   input  logic pll_en_i,
   output logic gate_on_o,
   output logic src_hit_o
);

   generate
      if (HAS_GATE) begin : g_gate
         assign gate_on_o = cfg_gate_i;
      end else begin : g_free
         assign gate_on_o = cfg_gate_i | 1'b1;
      end
   endgenerate

   assign src_hit_o = sel_q_i ? pll_en_i : base_en_i;

endmodule

// File: rtl/gmcd_div_core.sv
module gmcd_div_core #(
   parameter int RATIO_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gate_on_i,
   input  logic               src_hit_i,
   input  logic [RATIO_W-1:0] cfg_ratio_i,
   input  logic               cfg_sel_i,
   output logic               out_en_o,
   output logic [RATIO_W-1:0] ratio_q_o,
   output logic               sel_q_o,
   output logic               idle_o
);

   logic [RATIO_W-1:0] cnt_q;
   logic               terminal;
   logic               load;

   assign idle_o   = (cnt_q == '0);
   assign terminal = (cnt_q == (ratio_q_o - RATIO_W'(1)));
   // Capture settings only between periods, never mid-period.
   assign load     = !gate_on_i || (src_hit_i && terminal) || (idle_o && !src_hit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q_o <= RATIO_W'(1);
         sel_q_o   <= 1'b0;
      end else if (load) begin
         ratio_q_o <= cfg_ratio_i;
         sel_q_o   <= cfg_sel_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         out_en_o <= 1'b0;
      end else if (!gate_on_i) begin
         cnt_q    <= '0;
         out_en_o <= 1'b0;
      end else if (src_hit_i) begin
         if (terminal) begin
            cnt_q    <= '0;
            out_en_o <= 1'b1;
         end else begin
            cnt_q    <= cnt_q + RATIO_W'(1);
            out_en_o <= 1'b0;
         end
      end else begin
         out_en_o <= 1'b0;
      end
   end

endmodule

// File: rtl/gated_mux_divider.sv
module gated_mux_divider #(
   parameter gmcd_pkg::divm_e MODE     = gmcd_pkg::DIVM_DOUBLE,
   parameter int              DIV_W    = 8,
   parameter bit              HAS_GATE = 1'b1,
   localparam int             RATIO_W  = gmcd_pkg::ratio_width(MODE, DIV_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W-1:0]   cfg_div,
   input  logic               cfg_gate,
   input  logic               cfg_sel,
   input  logic               base_en,
   input  logic               pll_en,
   output logic               div_en_o,
   output logic [RATIO_W-1:0] ratio_o
);

   generate
      if (!(DIV_W == 3 || DIV_W == 4 || DIV_W == 8 || DIV_W == 16)) begin : g_bad_width
         $error("gated_mux_divider: DIV_W must be 3, 4, 8 or 16");
      end
      if (MODE == gmcd_pkg::DIVM_POW2 && DIV_W > 4) begin : g_bad_pow2
         $error("gated_mux_divider: power-of-two mode needs DIV_W of 3 or 4");
      end
   endgenerate

   logic [RATIO_W-1:0] cfg_ratio;
   logic               gate_on;
   logic               src_hit;
   logic               sel_q;
   logic               cnt_idle;

   gmcd_ratio_dec #(
      .MODE    (MODE),
      .DIV_W   (DIV_W),
      .RATIO_W (RATIO_W)
   ) u_dec (
      .field_i (cfg_div),
      .ratio_o (cfg_ratio)
   );

   gmcd_src_pick #(
      .HAS_GATE (HAS_GATE)
   ) u_pick (
      .cfg_gate_i (cfg_gate),
      .sel_q_i    (sel_q),
      .base_en_i  (base_en),
      .pll_en_i   (pll_en),
      .gate_on_o  (gate_on),
      .src_hit_o  (src_hit)
   );

   gmcd_div_core #(
      .RATIO_W (RATIO_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .gate_on_i   (gate_on),
      .src_hit_i   (src_hit),
      .cfg_ratio_i (cfg_ratio),
      .cfg_sel_i   (cfg_sel),
      .out_en_o    (div_en_o),
      .ratio_q_o   (ratio_o),
      .sel_q_o     (sel_q),
      .idle_o      (cnt_idle)
   );

endmodule

// File: rtl/gmcd_chk.sv
module gmcd_chk #(
   parameter int RATIO_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               gate_on,
   input logic               src_hit,
   input logic               cnt_idle,
   input logic               div_en_o,
   input logic [RATIO_W-1:0] ratio_o
);

   AST_GATE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_on |=> !div_en_o); // R6

   AST_PULSE_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      div_en_o |-> $past(src_hit)); // R7

   AST_SPACED_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
      (div_en_o && ratio_o > RATIO_W'(1)) |=> !div_en_o); // R2

   AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_o) |-> (div_en_o || $past(!gate_on) || $past(cnt_idle))); // R8

   AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_o != '0); // R9

endmodule

bind gated_mux_divider gmcd_chk #(.RATIO_W(RATIO_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gate_on  (gate_on),
   .src_hit  (src_hit),
   .cnt_idle (cnt_idle),
   .div_en_o (div_en_o),
   .ratio_o  (ratio_o)
);

// File: tb/gated_mux_divider_tb.sv
`timescale 1ns/1ps
module gated_mux_divider_tb;
   import gmcd_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n, gate, sel, base_en, pll_en;
   logic [15:0] div;
   logic        en_d, en_o, en_p, en_n;
   logic [9:0]  rat_d;
   logic [4:0]  rat_o;
   logic [8:0]  rat_p;
   logic [1:0]  rat_n;
   logic [3:0]  outs;
   int          n_chk = 0;
   int          n_err = 0;

   always #2 clk = ~clk;

   gated_mux_divider #(.MODE(DIVM_DOUBLE), .DIV_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_div(div[7:0]), .cfg_gate(gate), .cfg_sel(sel),
      .base_en(base_en), .pll_en(pll_en), .div_en_o(en_d), .ratio_o(rat_d));
   gated_mux_divider #(.MODE(DIVM_ONE), .DIV_W(4)) u_one (
      .clk(clk), .rst_n(rst_n), .cfg_div(div[3:0]), .cfg_gate(gate), .cfg_sel(sel),
      .base_en(base_en), .pll_en(pll_en), .div_en_o(en_o), .ratio_o(rat_o));
   gated_mux_divider #(.MODE(DIVM_POW2), .DIV_W(3)) u_pow (
      .clk(clk), .rst_n(rst_n), .cfg_div(div[2:0]), .cfg_gate(gate), .cfg_sel(sel),
      .base_en(base_en), .pll_en(pll_en), .div_en_o(en_p), .ratio_o(rat_p));
   gated_mux_divider #(.MODE(DIVM_NONE), .DIV_W(4)) u_none (
      .clk(clk), .rst_n(rst_n), .cfg_div(div[3:0]), .cfg_gate(gate), .cfg_sel(sel),
      .base_en(base_en), .pll_en(pll_en), .div_en_o(en_n), .ratio_o(rat_n));

   assign outs = {en_n, en_p, en_o, en_d};

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // Cycles from the current sample to the next sample where output idx is high.
   task automatic next_high(input int idx, output int gap);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!outs[idx]);
   endtask

   task automatic period_of(input int idx, output int iv);
      int g;
      for (int k = 0; k < 3; k++) next_high(idx, g);
      next_high(idx, iv);
   endtask

   task automatic set_cfg(input int d, input logic s, input logic g);
      @(negedge clk);
      div  = 16'(d);
      sel  = s;
      gate = g;
   endtask

   // PLL strobe: one pulse every third cycle.
   initial begin
      int ph = 0;
      pll_en = 1'b0;
      forever begin
         @(posedge clk);
         ph = (ph == 2) ? 0 : ph + 1;
         pll_en <= (ph == 0);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 out during reset", int'(outs), 0);
      chk("R1 ratio during reset", int'(rat_d), 1);
      chk("R1 ratio during reset one-based", int'(rat_o), 1);
   endtask

   task automatic t_double();
      int iv;
      set_cfg(0, 1'b0, 1'b1);
      period_of(0, iv);
      chk("R2 doubled N=0 interval", iv, 2);
      chk("R2 doubled N=0 status", int'(rat_d), 2);
      set_cfg(2, 1'b0, 1'b1);
      period_of(0, iv);
      chk("R2 doubled N=2 interval", iv, 6);
      chk("R2 doubled N=2 status", int'(rat_d), 6);
   endtask

   task automatic t_one();
      int iv;
      set_cfg(0, 1'b0, 1'b1);
      period_of(1, iv);
      chk("R3 one-based N=0 interval", iv, 1);
      chk("R3 one-based N=0 status", int'(rat_o), 1);
      set_cfg(4, 1'b0, 1'b1);
      period_of(1, iv);
      chk("R3 one-based N=4 interval", iv, 5);
      set_cfg(15, 1'b0, 1'b1);
      period_of(1, iv);
      chk("R3 one-based N=15 interval", iv, 16);
      chk("R3 one-based N=15 status", int'(rat_o), 16);
   endtask

   task automatic t_pow2();
      int iv;
      set_cfg(0, 1'b0, 1'b1);
      period_of(2, iv);
      chk("R4 pow2 N=0 interval", iv, 2);
      set_cfg(3, 1'b0, 1'b1);
      period_of(2, iv);
      chk("R4 pow2 N=3 interval", iv, 16);
      set_cfg(7, 1'b0, 1'b1);
      period_of(2, iv);
      chk("R4 pow2 N=7 interval", iv, 256);
      chk("R4 pow2 N=7 status", int'(rat_p), 256);
   endtask

   task automatic t_none();
      int iv;
      set_cfg(9, 1'b0, 1'b1);
      period_of(3, iv);
      chk("R5 no divider field ignored interval", iv, 1);
      chk("R5 no divider status", int'(rat_n), 1);
   endtask

   task automatic t_select();
      int iv;
      set_cfg(0, 1'b1, 1'b1);
      period_of(0, iv);
      chk("R7 PLL source doubled N=0 interval", iv, 6);
      period_of(1, iv);
      chk("R7 PLL source one-based N=0 interval", iv, 3);
      set_cfg(0, 1'b0, 1'b1);
      period_of(0, iv);
      chk("R7 base source restored interval", iv, 2);
   endtask

   task automatic t_gate();
      int highs = 0;
      int g;
      set_cfg(1, 1'b0, 1'b0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (outs != 4'b0) highs++;
      end
      chk("R6 gated off pulse count", highs, 0);
      gate = 1'b1;
      next_high(0, g);
      chk("R6 first pulse after re-enable", g, 4);
   endtask

   task automatic t_boundary();
      int g;
      int iv;
      set_cfg(9, 1'b0, 1'b1);
      period_of(0, iv);
      chk("R2 doubled N=9 interval", iv, 20);
      for (int k = 0; k < 5; k++) @(negedge clk);
      div = 16'd0;
      @(negedge clk);
      chk("R9 status holds mid-period", int'(rat_d), 20);
      next_high(0, g);
      chk("R8 running period completes", g + 6, 20);
      next_high(0, iv);
      chk("R8 new ratio after boundary", iv, 2);
      chk("R9 status after boundary", int'(rat_d), 2);
   endtask

   initial begin
      rst_n   = 1'b0;
      gate    = 1'b1;
      sel     = 1'b0;
      div     = 16'd0;
      base_en = 1'b1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_double();
      t_one();
      t_pow2();
      t_none();
      t_select();
      t_gate();
      t_boundary();
      finish_run();
   end

endmodule